// File: doc/BRIEF.md
# Reversible-Gate Arithmetic and Logic Unit

This block is an N-bit arithmetic and logic unit (four bits by default). Every bit of it is built only from reversible primitives: controlled-NOT, doubly-controlled-NOT, the Peres gate, the universal reversible gate and the controlled-swap (Fredkin) gate. Constant ancilla values are tied to the spare inputs of these gates. Each bit of the logic half is a slice that produces OR, AND, NOT A and XOR of its operand bits. A 4:1 multiplexer made of three controlled-swap gates then picks one of the four. A parameter selects one of two structural forms for the slice. Form 0 uses a Peres gate followed by a doubly-controlled-NOT. Form 1 uses a universal reversible gate followed by a controlled-NOT. In both forms, one controlled-NOT with a constant 1 acts as the inverter.

The arithmetic half is a ripple adder. Each bit of it is a full adder built from two Peres gates. Its second operand comes from a controlled-swap 4:1 multiplexer that picks B, NOT B, all zeros or all ones. A single controlled-swap gate per bit chooses between the arithmetic and the logic result. A second controlled-swap gate forces the carry-out to zero in logic mode. The result, the carry-out and a debug bus of the unused (garbage) gate outputs of the logic slices are registered once before they leave the block.

Top module: `rev_alu`

## Requirements
- R1: While rst_n is low, result, cout and garbage are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: With mode=1 and sel=2'b00, result is the bitwise OR of op_a and op_b.
- R4: With mode=1 and sel=2'b01, result is the bitwise AND of op_a and op_b.
- R5: With mode=1 and sel=2'b10, result is the bitwise complement of op_a, and op_b has no effect on it.
- R6: With mode=1 and sel=2'b11, result is the bitwise XOR of op_a and op_b.
- R7: With mode=1, cout is 0 and cin has no effect on result or cout.
- R8: With mode=0, the second operand Y is op_b for sel=2'b00, ~op_b for 2'b01, all zeros for 2'b10 and all ones for 2'b11. {cout, result} equals op_a + Y + cin, computed in WIDTH+1 bits.
- R9: garbage bits [3i+2:3i] belong to bit slice i, in every mode. In form 0 they are {op_a[i], op_a[i]^op_b[i], 1}. In form 1 they are {op_b[i], op_a[i], op_a[i]}.
- R10: Both structural forms give the same result and cout for every input combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sel | input | 2 | Function select within the chosen half |
| mode | input | 1 | 0 selects the arithmetic result, 1 selects the logic result |
| cin | input | 1 | Carry into the arithmetic half |
| result | output | WIDTH | Registered result |
| cout | output | 1 | Registered carry-out, zero in logic mode |
| garbage | output | 3*WIDTH | Registered unused gate outputs of the logic slices |

## Verification
The bench sweeps every operand, select, mode and carry-in combination on both structural forms, and then adds seeded random vectors. Errors in the ancilla ties are the main target. A constant wired to the wrong value turns OR into XOR, or NOT A into a copy of A, for only some operand pairs. A swapped controlled-swap data input exchanges two functions, which shows up as mismatches under one select code. Further targets are the cases where cin must be ignored, the forced zero carry in logic mode, and the borrow and wrap-around cases of decrement and subtract. A design that leaked cin into logic mode, or whose carry chain failed to ripple, would differ from the bench's reference there.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;

    // number of garbage bits exported per logic slice
    localparam int SLICE_GW = 3;

    // structural forms of the logic slice
    localparam int FORM_PERES_TOFFOLI = 0;
    localparam int FORM_URG_CNOT      = 1;

    // controlled-NOT: first output is x (pass-through), second is x ^ y
    function automatic logic cnot_q(input logic x, input logic y);
        return x ^ y;
    endfunction

    // doubly-controlled-NOT: third output flips z when x and y are both 1
    function automatic logic ccnot_r(input logic x, input logic y, input logic z);
        return z ^ (x & y);
    endfunction

    // Peres gate: second output x ^ y, third output z ^ (x & y)
    function automatic logic peres_q(input logic x, input logic y);
        return x ^ y;
    endfunction

    function automatic logic peres_r(input logic x, input logic y, input logic z);
        return z ^ (x & y);
    endfunction

    // universal reversible gate: first output (x | y) ^ z, third (x & y) ^ z
    function automatic logic urg_p(input logic x, input logic y, input logic z);
        return (x | y) ^ z;
    endfunction

    function automatic logic urg_r(input logic x, input logic y, input logic z);
        return (x & y) ^ z;
    endfunction

    // controlled swap: with control c low the second output carries d0,
    // with c high it carries d1
    function automatic logic cswap_q(input logic c, input logic d0, input logic d1);
        return (~c & d0) | (c & d1);
    endfunction

endpackage

// File: rtl/rev_mux4.sv
module rev_mux4
    import rev_alu_pkg::*;
(
    input  logic       in0,
    input  logic       in1,
    input  logic       in2,
    input  logic       in3,
    input  logic [1:0] pick,
    output logic       out
);
    logic low_pair;
    logic high_pair;

    // two swaps steered by pick[0], the control passes through the first
    always_comb begin
        low_pair  = cswap_q(pick[0], in0, in1);
        high_pair = cswap_q(pick[0], in2, in3);
        out       = cswap_q(pick[1], low_pair, high_pair);
    end
endmodule

// File: rtl/rev_logic_slice.sv
module rev_logic_slice
    import rev_alu_pkg::*;
#(
    parameter int FORM = FORM_PERES_TOFFOLI
) (
    input  logic                a_bit,
    input  logic                b_bit,
    input  logic [1:0]          pick,
    output logic                y_bit,
    output logic [SLICE_GW-1:0] garb
);
    logic f_or;
    logic f_and;
    logic f_not;
    logic f_xor;

    generate
        if (FORM == FORM_PERES_TOFFOLI) begin : g_peres_toffoli
            // Peres with z tied low gives XOR and AND; a doubly-controlled
            // NOT with its second control tied high folds them into OR
            always_comb begin
                f_xor = peres_q(a_bit, b_bit);
                f_and = peres_r(a_bit, b_bit, 1'b0);
                f_or  = ccnot_r(f_xor, 1'b1, f_and);
                f_not = cnot_q(a_bit, 1'b1);
                garb  = {a_bit, f_xor, 1'b1};
            end
        end else begin : g_urg_cnot
            // URG with z tied low gives OR and AND; a CNOT gives XOR
            always_comb begin
                f_or  = urg_p(a_bit, b_bit, 1'b0);
                f_and = urg_r(a_bit, b_bit, 1'b0);
                f_xor = cnot_q(a_bit, b_bit);
                f_not = cnot_q(a_bit, 1'b1);
                garb  = {b_bit, a_bit, a_bit};
            end
        end
    endgenerate

    rev_mux4 u_pick (
        .in0  (f_or),
        .in1  (f_and),
        .in2  (f_not),
        .in3  (f_xor),
        .pick (pick),
        .out  (y_bit)
    );
endmodule

// File: rtl/rev_arith_unit.sv
module rev_arith_unit
    import rev_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       pick,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out
);
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] b_inv;
    logic [WIDTH-1:0] y_op;
    logic [WIDTH-1:0] half_s;
    logic [WIDTH-1:0] half_c;

    assign carry[0] = c_in;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign b_inv[i] = cnot_q(b_in[i], 1'b1);

            rev_mux4 u_yop (
                .in0  (b_in[i]),
                .in1  (b_inv[i]),
                .in2  (1'b0),
                .in3  (1'b1),
                .pick (pick),
                .out  (y_op[i])
            );

            // full adder from two chained Peres gates
            always_comb begin
                half_s[i]   = peres_q(a_in[i], y_op[i]);
                half_c[i]   = peres_r(a_in[i], y_op[i], 1'b0);
                sum[i]      = peres_q(half_s[i], carry[i]);
                carry[i+1]  = peres_r(half_s[i], carry[i], half_c[i]);
            end
        end
    endgenerate

    assign c_out = carry[WIDTH];
endmodule

// File: rtl/rev_alu.sv
module rev_alu
    import rev_alu_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int FORM  = FORM_PERES_TOFFOLI
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WIDTH-1:0]             op_a,
    input  logic [WIDTH-1:0]             op_b,
    input  logic [1:0]                   sel,
    input  logic                         mode,
    input  logic                         cin,
    output logic [WIDTH-1:0]             result,
    output logic                         cout,
    output logic [SLICE_GW*WIDTH-1:0]    garbage
);
    localparam int GW = SLICE_GW * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             co;
        logic [GW-1:0]    garb;
    } out_state_t;

    out_state_t state_d;
    out_state_t state_q;

    logic [WIDTH-1:0] arith_sum;
    logic             arith_co;
    logic [WIDTH-1:0] logic_res;
    logic [GW-1:0]    logic_garb;

    rev_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a_in  (op_a),
        .b_in  (op_b),
        .pick  (sel),
        .c_in  (cin),
        .sum   (arith_sum),
        .c_out (arith_co)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            rev_logic_slice #(.FORM(FORM)) u_slice (
                .a_bit (op_a[i]),
                .b_bit (op_b[i]),
                .pick  (sel),
                .y_bit (logic_res[i]),
                .garb  (logic_garb[SLICE_GW*i +: SLICE_GW])
            );
        end
    endgenerate

    // result steering through one controlled swap per bit; a second swap
    // with a constant zero input blanks the carry in logic mode
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < WIDTH; i++) begin
            state_d.res[i] = cswap_q(mode, arith_sum[i], logic_res[i]);
        end
        state_d.co   = cswap_q(mode, arith_co, 1'b0);
        state_d.garb = logic_garb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result  = state_q.res;
    assign cout    = state_q.co;
    assign garbage = state_q.garb;
endmodule

// File: rtl/rev_alu_checker.sv
module rev_alu_checker
    import rev_alu_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int FORM  = FORM_PERES_TOFFOLI
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [WIDTH-1:0]          op_a,
    input logic [WIDTH-1:0]          op_b,
    input logic [1:0]                sel,
    input logic                      mode,
    input logic                      cin,
    input logic [WIDTH-1:0]          result,
    input logic                      cout,
    input logic [SLICE_GW*WIDTH-1:0] garbage
);
    assert_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && sel == 2'b00) |=> result == ($past(op_a) | $past(op_b)));

    assert_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && sel == 2'b01) |=> result == ($past(op_a) & $past(op_b)));

    assert_not_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && sel == 2'b10) |=> result == ~$past(op_a));

    assert_xor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && sel == 2'b11) |=> result == ($past(op_a) ^ $past(op_b)));

    assert_logic_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> !cout);

    assert_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && sel == 2'b10 && !cin) |=> (result == $past(op_a) && !cout));

    generate
        if (FORM == FORM_PERES_TOFFOLI) begin : g_f0
            assert_garb_R9: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> garbage[2:0] == {$past(op_a[0]), $past(op_a[0] ^ op_b[0]), 1'b1});
        end else begin : g_f1
            assert_garb_R9: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> garbage[2:0] == {$past(op_b[0]), $past(op_a[0]), $past(op_a[0])});
        end
    endgenerate
endmodule

bind rev_alu rev_alu_checker #(.WIDTH(WIDTH), .FORM(FORM)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .sel     (sel),
    .mode    (mode),
    .cin     (cin),
    .result  (result),
    .cout    (cout),
    .garbage (garbage)
);

// File: tb/rev_alu_test.sv
module rev_alu_test;
    localparam int WIDTH    = 4;
    localparam int GW       = 3 * WIDTH;
    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic [1:0]       sel = '0;
    logic             mode = 1'b0;
    logic             cin = 1'b0;
    logic [WIDTH-1:0] res0, res1;
    logic             co0, co1;
    logic [GW-1:0]    garb0, garb1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rev_alu #(.WIDTH(WIDTH), .FORM(0)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sel(sel),
        .mode(mode), .cin(cin), .result(res0), .cout(co0), .garbage(garb0));

    rev_alu #(.WIDTH(WIDTH), .FORM(1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sel(sel),
        .mode(mode), .cin(cin), .result(res1), .cout(co1), .garbage(garb1));

    // reference: {cout, result} from the requirements
    function automatic logic [WIDTH:0] ref_out(input logic [WIDTH-1:0] a,
            input logic [WIDTH-1:0] b, input logic [1:0] s, input logic m,
            input logic c);
        logic [WIDTH-1:0] y;
        if (m) begin
            case (s)
                2'b00:   return {1'b0, a | b};
                2'b01:   return {1'b0, a & b};
                2'b10:   return {1'b0, ~a};
                default: return {1'b0, a ^ b};
            endcase
        end
        case (s)
            2'b00:   y = b;
            2'b01:   y = ~b;
            2'b10:   y = '0;
            default: y = '1;
        endcase
        return {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, c};
    endfunction

    function automatic logic [GW-1:0] ref_garb(input int form,
            input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        logic [GW-1:0] g;
        for (int i = 0; i < WIDTH; i++) begin
            if (form == 0) g[3*i +: 3] = {a[i], a[i] ^ b[i], 1'b1};
            else           g[3*i +: 3] = {b[i], a[i], a[i]};
        end
        return g;
    endfunction

    function automatic string req_tag(input logic m, input logic [1:0] s);
        if (!m) return "R8";
        case (s)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [GW:0] act, input logic [GW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h sel=%b mode=%b cin=%b)",
                     tag, act, exp, op_a, op_b, sel, mode, cin);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
            input logic [1:0] s, input logic m, input logic c);
        logic [WIDTH:0] e;
        @(negedge clk);
        op_a = a; op_b = b; sel = s; mode = m; cin = c;
        e = ref_out(a, b, s, m, c);
        @(negedge clk);
        check({req_tag(m, s), " R2 form0 result"}, GW'(res0), GW'(e[WIDTH-1:0]));
        check({req_tag(m, s), " R2 form1 result"}, GW'(res1), GW'(e[WIDTH-1:0]));
        check(m ? "R7 form0 cout" : "R8 form0 cout", GW'(co0), GW'(e[WIDTH]));
        check(m ? "R7 form1 cout" : "R8 form1 cout", GW'(co1), GW'(e[WIDTH]));
        check("R9 form0 garbage", {1'b0, garb0}, {1'b0, ref_garb(0, a, b)});
        check("R9 form1 garbage", {1'b0, garb1}, {1'b0, ref_garb(1, a, b)});
        check("R10 forms agree", {co0, res0}, {co1, res1});
    endtask

    initial begin
        // R1: outputs held at zero during reset even with live inputs
        op_a = '1; op_b = '1; mode = 1'b1; sel = 2'b00; cin = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset result", GW'(res0 | res1), '0);
        check("R1 reset cout", GW'(co0 | co1), '0);
        check("R1 reset garbage", {1'b0, garb0 | garb1}, '0);
        rst_n = 1'b1;

        // exhaustive sweep, covers R3..R8 and cin ignored in logic mode (R7)
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < (1 << WIDTH); a++)
                        for (int b = 0; b < (1 << WIDTH); b++)
                            apply(WIDTH'(a), WIDTH'(b), 2'(s), 1'(m), 1'(c));

        // directed corners: decrement of zero wraps, increment of all ones
        apply('0, '0, 2'b11, 1'b0, 1'b0);
        apply('1, '0, 2'b10, 1'b0, 1'b1);
        apply('0, '1, 2'b01, 1'b0, 1'b1);
        // R5: op_b change with NOT A selected leaves result unchanged
        apply(4'h5, 4'h0, 2'b10, 1'b1, 1'b0);
        apply(4'h5, 4'hF, 2'b10, 1'b1, 1'b1);

        // seeded random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++)
            apply(WIDTH'($urandom), WIDTH'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule